// File: doc/BRIEF.md
# Dimension-Ordered Route Computation Unit

This block decides, for each packet entering one port of a two-dimensional mesh router, which of the five output directions the packet must leave by. The router's own node number is fixed by a parameter. When a header flit arrives, the block reads the destination field and splits both node numbers into a column and a row, using row-major numbering. It then resolves the horizontal dimension completely before it looks at the vertical one. The resulting direction is registered as a one-hot select, together with a valid flag.

Under wormhole switching, the body and tail flits of a packet carry no address. They follow the route the header set up, so the block holds the registered direction unchanged while those flits pass. It clears the route once the tail flit has been accepted. One instance sits beside each input buffer of a router. The crossbar and the arbiter downstream use its select.

Top module: `xy_route_unit`

## Requirements
- R1: After reset, `route_valid_o` is 0 and `dir_o` is 0.
- R2: The direction encoding in `dir_o` is bit 0 Local, bit 1 North, bit 2 East, bit 3 South, bit 4 West. A flit's kind is taken from its two top bits: 00 header, 01 body, 10 tail, 11 reserved. The destination address is taken from the low `ADDR_W` bits. The column of a node is its address modulo `MESH_COLS`, and its row is its address divided by `MESH_COLS`. When a valid header has a destination column below the router's own column, the edge that accepts it makes `dir_o` West (bit 4) and `route_valid_o` 1, whatever the rows are.
- R3: When a valid header has a destination column above the router's own column, the route becomes East (bit 2), whatever the rows are.
- R4: When a valid header has a destination column equal to the router's own, the route becomes North (bit 1) if the destination row is smaller than the router's row, and South (bit 3) if it is larger.
- R5: When a valid header's destination column and row both equal the router's own, the route becomes Local (bit 0).
- R6: A valid body flit leaves `dir_o` and `route_valid_o` unchanged. During the cycle in which a tail flit is presented, the route set by the header is still shown.
- R7: On the edge that accepts a valid tail flit, `route_valid_o` becomes 0 and `dir_o` becomes 0.
- R8: A valid flit of the reserved kind leaves `dir_o` and `route_valid_o` unchanged.
- R9: While `flit_valid_i` is 0, `dir_o` and `route_valid_o` do not change, whatever `flit_i` carries.
- R10: A valid header that arrives while a route is held replaces that route with the one computed from the new header.
- R11: A body or tail flit that arrives while no route is held leaves `route_valid_o` at 0.
- R12: Whenever `route_valid_o` is 1, exactly one bit of `dir_o` is set. Whenever it is 0, `dir_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flit_i | input | FLIT_W | Incoming flit: kind in the top two bits, destination in the low ADDR_W bits |
| flit_valid_i | input | 1 | Qualifies `flit_i` for this cycle |
| dir_o | output | 5 | One-hot output direction (Local, North, East, South, West from bit 0) |
| route_valid_o | output | 1 | A packet route is currently held |

## Verification
The bench goes after the tie-break corners. A destination in the router's own row but another column must go East or West. A destination in a different row and a different column must still go horizontally first. A design that compared rows first, or that let a row mismatch override a column mismatch, would send such packets North or South. It also sends a body and a tail with no header ahead of them, interleaves reserved-kind and unqualified flits, and sends headers with no tail in between. A design that treated the reserved kind as a tail would drop a held route. One that ignored the valid strobe would change direction on idle cycles. One that failed to reload on a back-to-back header would keep steering the new packet to the old port.

// File: rtl/xyr_pkg.sv
package xyr_pkg;

    // Flit kind carried in the two most significant bits of a flit.
    typedef enum logic [1:0] {
        FK_HEAD = 2'b00,
        FK_BODY = 2'b01,
        FK_TAIL = 2'b10,
        FK_RSVD = 2'b11
    } flit_kind_e;

    // Output direction positions within the one-hot select.
    localparam int DIR_COUNT = 5;
    localparam int DIR_LOCAL = 0;
    localparam int DIR_NORTH = 1;
    localparam int DIR_EAST  = 2;
    localparam int DIR_SOUTH = 3;
    localparam int DIR_WEST  = 4;

    typedef logic [DIR_COUNT-1:0] dir_vec_t;

    // Registered routing state for the packet in flight.
    typedef struct packed {
        logic     held;
        dir_vec_t dir;
    } route_state_t;

endpackage

// File: rtl/xyr_coord_split.sv
// Splits a row-major node number into column and row.
module xyr_coord_split #(
    parameter int ADDR_W    = 5,
    parameter int MESH_COLS = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] col_o,
    output logic [ADDR_W-1:0] row_o
);

    localparam logic [ADDR_W-1:0] COLS_V = ADDR_W'(MESH_COLS);

    always_comb begin
        col_o = addr_i % COLS_V;
        row_o = addr_i / COLS_V;
    end

endmodule

// File: rtl/xyr_dir_select.sv
// Dimension-ordered direction choice: the column difference is settled
// before the row is examined at all.
module xyr_dir_select
    import xyr_pkg::*;
#(
    parameter int COORD_W = 5
) (
    input  logic [COORD_W-1:0] here_col_i,
    input  logic [COORD_W-1:0] here_row_i,
    input  logic [COORD_W-1:0] dest_col_i,
    input  logic [COORD_W-1:0] dest_row_i,
    output dir_vec_t           dir_o
);

    always_comb begin
        dir_o = '0;
        if (dest_col_i < here_col_i) begin
            dir_o[DIR_WEST] = 1'b1;
        end else if (dest_col_i > here_col_i) begin
            dir_o[DIR_EAST] = 1'b1;
        end else if (dest_row_i < here_row_i) begin
            dir_o[DIR_NORTH] = 1'b1;
        end else if (dest_row_i > here_row_i) begin
            dir_o[DIR_SOUTH] = 1'b1;
        end else begin
            dir_o[DIR_LOCAL] = 1'b1;
        end
    end

endmodule

// File: rtl/xyr_route_hold.sv
// Holds the route of the packet in flight from header to tail.
module xyr_route_hold
    import xyr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take_i,
    input  flit_kind_e   kind_i,
    input  dir_vec_t     fresh_dir_i,
    output route_state_t state_o
);

    route_state_t route_d, route_q;

    always_comb begin
        route_d = route_q;
        if (take_i) begin
            unique case (kind_i)
                FK_HEAD: begin
                    route_d.held = 1'b1;
                    route_d.dir  = fresh_dir_i;
                end
                FK_TAIL: begin
                    route_d.held = 1'b0;
                    route_d.dir  = '0;
                end
                FK_BODY, FK_RSVD: begin
                    route_d = route_q;
                end
                default: route_d = route_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= '0;
        end else begin
            route_q <= route_d;
        end
    end

    assign state_o = route_q;

endmodule

// File: rtl/xy_route_unit.sv
module xy_route_unit
    import xyr_pkg::*;
#(
    parameter int FLIT_W    = 12,
    parameter int ADDR_W    = 5,
    parameter int MESH_COLS = 4,
    parameter int MESH_ROWS = 4,
    parameter int NODE_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLIT_W-1:0] flit_i,
    input  logic              flit_valid_i,
    output logic [4:0]        dir_o,
    output logic              route_valid_o
);

    localparam int KIND_LO  = FLIT_W - 2;
    localparam int NODE_CNT = MESH_COLS * MESH_ROWS;
    localparam logic [ADDR_W-1:0] HERE_COL = ADDR_W'(NODE_ADDR % MESH_COLS);
    localparam logic [ADDR_W-1:0] HERE_ROW = ADDR_W'(NODE_ADDR / MESH_COLS);

    initial begin
        if (NODE_ADDR >= NODE_CNT || FLIT_W < ADDR_W + 3) begin
            $error("xy_route_unit: node address or flit width out of range");
        end
    end

    flit_kind_e          kind;
    logic [ADDR_W-1:0]   dest_addr;
    logic [ADDR_W-1:0]   dest_col;
    logic [ADDR_W-1:0]   dest_row;
    dir_vec_t            fresh_dir;
    route_state_t        route;
    logic                unused_middle_bits;

    assign kind               = flit_kind_e'(flit_i[FLIT_W-1:KIND_LO]);
    assign dest_addr          = flit_i[ADDR_W-1:0];
    assign unused_middle_bits = ^flit_i[KIND_LO-1:ADDR_W];

    xyr_coord_split #(
        .ADDR_W    (ADDR_W),
        .MESH_COLS (MESH_COLS)
    ) i_dest_split (
        .addr_i (dest_addr),
        .col_o  (dest_col),
        .row_o  (dest_row)
    );

    xyr_dir_select #(
        .COORD_W (ADDR_W)
    ) i_dir_select (
        .here_col_i (HERE_COL),
        .here_row_i (HERE_ROW),
        .dest_col_i (dest_col),
        .dest_row_i (dest_row),
        .dir_o      (fresh_dir)
    );

    xyr_route_hold i_route_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (flit_valid_i),
        .kind_i      (kind),
        .fresh_dir_i (fresh_dir),
        .state_o     (route)
    );

    assign dir_o         = route.dir;
    assign route_valid_o = route.held;

endmodule

// File: rtl/xyr_checker.sv
module xyr_checker #(
    parameter int FLIT_W    = 12,
    parameter int ADDR_W    = 5,
    parameter int NODE_ADDR = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FLIT_W-1:0] flit_i,
    input logic              flit_valid_i,
    input logic [4:0]        dir_o,
    input logic              route_valid_o
);

    logic [1:0] kind;
    assign kind = flit_i[FLIT_W-1:FLIT_W-2];

    // R12: one-hot while held, zero otherwise
    p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid_o |-> $onehot(dir_o));
    p_zero_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !route_valid_o |-> (dir_o == 5'b0));

    // R9: unqualified cycles change nothing
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flit_valid_i |=> ($stable(dir_o) && $stable(route_valid_o)));

    // R8: reserved kind is ignored
    p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid_i && kind == 2'b11) |=> ($stable(dir_o) && $stable(route_valid_o)));

    // R6: body keeps the route
    p_body_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid_i && kind == 2'b01) |=> ($stable(dir_o) && $stable(route_valid_o)));

    // R7: tail releases the route
    p_tail_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid_i && kind == 2'b10) |=> !route_valid_o);

    // R10: a header always establishes a route
    p_head_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid_i && kind == 2'b00) |=> route_valid_o);

    // R5: own address routes Local
    p_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid_i && kind == 2'b00 && flit_i[ADDR_W-1:0] == ADDR_W'(NODE_ADDR))
        |=> (dir_o == 5'b00001));

endmodule

bind xy_route_unit xyr_checker #(
    .FLIT_W    (FLIT_W),
    .ADDR_W    (ADDR_W),
    .NODE_ADDR (NODE_ADDR)
) i_xyr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .flit_i        (flit_i),
    .flit_valid_i  (flit_valid_i),
    .dir_o         (dir_o),
    .route_valid_o (route_valid_o)
);

// File: tb/test_xy_route_unit.sv
module test_xy_route_unit;

    localparam int FLIT_W = 12;
    localparam int ADDR_W = 5;
    localparam int COLS   = 4;
    localparam int NODE   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [FLIT_W-1:0] flit_i = '0;
    logic              flit_valid_i = 1'b0;
    logic [4:0]        dir_o;
    logic              route_valid_o;

    int    n_checks = 0;
    int    n_errors = 0;
    logic  exp_valid = 1'b0;
    logic [4:0] exp_dir = 5'b0;
    string pend_tag = "R1";
    logic  done = 1'b0;

    always #2 clk = ~clk;

    xy_route_unit #(
        .FLIT_W    (FLIT_W),
        .ADDR_W    (ADDR_W),
        .MESH_COLS (COLS),
        .MESH_ROWS (4),
        .NODE_ADDR (NODE)
    ) i_xy_route_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .flit_i        (flit_i),
        .flit_valid_i  (flit_valid_i),
        .dir_o         (dir_o),
        .route_valid_o (route_valid_o)
    );

    // Reference: column first, then row; bit0 L, 1 N, 2 E, 3 S, 4 W
    function automatic logic [4:0] ref_dir(input int dest);
        int dc = dest % COLS;
        int dr = dest / COLS;
        int hc = NODE % COLS;
        int hr = NODE / COLS;
        if (dc < hc) return 5'b10000;
        if (dc > hc) return 5'b00100;
        if (dr < hr) return 5'b00010;
        if (dr > hr) return 5'b01000;
        return 5'b00001;
    endfunction

    task automatic check_now();
        n_checks++;
        if (dir_o !== exp_dir || route_valid_o !== exp_valid) begin
            n_errors++;
            $display("FAIL %s: dir=%b valid=%b expected dir=%b valid=%b",
                     pend_tag, dir_o, route_valid_o, exp_dir, exp_valid);
        end
    endtask

    // Check the result of the previous step, then present a new flit.
    task automatic step(input logic vld, input logic [1:0] kind, input int dest,
                        input string tag);
        @(negedge clk);
        check_now();
        flit_valid_i = vld;
        flit_i = {kind, 5'($urandom_range(31)), 5'(dest)};
        if (vld) begin
            if (kind == 2'b00) begin
                exp_valid = 1'b1;
                exp_dir   = ref_dir(dest);
            end else if (kind == 2'b10) begin
                exp_valid = 1'b0;
                exp_dir   = 5'b0;
            end
        end
        pend_tag = tag;
    endtask

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        check_now();                       // R1 reset state
        rst_n = 1'b1;
        pend_tag = "R1";
        step(1'b0, 2'b00, 0, "R1");
        step(1'b1, 2'b00, 4, "R2");        // same row, column left -> West
        step(1'b1, 2'b00, 0, "R2");        // row and column differ -> West
        step(1'b1, 2'b00, 12, "R2");
        step(1'b1, 2'b00, 7, "R3");        // same row -> East
        step(1'b1, 2'b00, 14, "R3");       // other row -> East
        step(1'b1, 2'b00, 1, "R4");        // North
        step(1'b1, 2'b00, 13, "R4");       // South
        step(1'b1, 2'b00, 5, "R5");        // Local
        step(1'b1, 2'b00, 2, "R10");       // replaces Local with East
        step(1'b1, 2'b01, 8, "R6");        // body keeps East
        step(1'b1, 2'b11, 0, "R8");        // reserved ignored
        step(1'b0, 2'b10, 0, "R9");        // unqualified tail ignored
        step(1'b0, 2'b00, 4, "R9");        // unqualified header ignored
        step(1'b1, 2'b10, 0, "R6");        // tail presented, route still shown
        step(1'b1, 2'b01, 4, "R7");        // check shows release after tail
        step(1'b1, 2'b10, 4, "R11");       // body/tail with no route
        step(1'b1, 2'b11, 4, "R11");
        step(1'b1, 2'b00, 9, "R8");        // South then reserved
        step(1'b1, 2'b11, 3, "R8");
        step(1'b1, 2'b10, 3, "R7");
        for (int i = 0; i < 3000; i++) begin
            logic       v = ($urandom_range(3) != 0);
            logic [1:0] k = 2'($urandom_range(3));
            int         d = $urandom_range(15);
            string      t = !v ? "R9" : (k == 2'b00) ? "R10" :
                            (k == 2'b01) ? "R6" : (k == 2'b10) ? "R7" : "R8";
            step(v, k, d, t);
        end
        @(negedge clk);
        check_now();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule